// File: doc/BRIEF.md
# Return and Shadow-Restore Sequencer

This block executes the two subroutine-return instructions of a small 8-bit controller core. One is the return from an interrupt. It pops the hardware return stack into the program counter and sets one of the two global interrupt-enable bits. It can also copy fast shadow copies back into the accumulator (W), STATUS and the bank-select register. The other is the literal return, used to end lookup tables. It pops the stack into the program counter and writes an 8-bit constant into W.

Each instruction cycle has four phases, and the block advances one phase per clock. An instruction word is sampled in phase 0 of an instruction cycle. All architectural updates happen together at the end of phase 3 of that cycle. The cycle that follows is a flush: `busy` is high for its four phases and no new word is taken. A push port preloads the 31-entry return stack, and a load port fills the shadow copies. These two ports stand in for the call path and for interrupt entry.

Top module: `ret_seq`

## Requirements
- R1: An interrupt return is recognised only when bits 15:1 of the word are 000000000001000, with bit 0 as the restore flag s. A literal return is recognised only when bits 15:8 are 0x0C, with bits 7:0 as the literal k.
- R2: A word is taken only in phase 0 while `busy` is low. Its results appear after the clock edge that ends phase 3 of that cycle. `busy` is then high for exactly four clocks.
- R3: Each recognised instruction raises `pop` for one clock in phase 3. If the stack is not empty, `pc` takes the top-of-stack value and `depth` drops by one.
- R4: A literal return writes k to `wreg` and leaves `status`, `bank_sel`, `ie_high` and `ie_low` unchanged.
- R5: An interrupt return with s=1 loads `wreg`, `status` and `bank_sel` from their shadow copies. With s=0 it leaves all three unchanged.
- R6: An interrupt return sets `ie_high` when `prio_en` is 0 or `in_high_isr` is 1, and otherwise sets `ie_low`. The other enable bit keeps its value.
- R7: A pop on an empty stack loads `pc` with 0 and sets `underflow`. `underflow` stays set until reset.
- R8: A word that matches neither encoding changes no register and no stack entry, and raises neither `pop` nor `busy`.
- R9: A valid word presented while `busy` is high is ignored.
- R10: After reset, `pc`, `wreg`, `status`, `bank_sel`, both enable bits, `depth`, `underflow` and `busy` are all 0.
- R11: `push_en` adds `push_addr` on top of the stack and raises `depth` by one. A push while 31 entries are held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 16 | Instruction word |
| instr_valid | input | 1 | Instruction word present |
| push_en | input | 1 | Push push_addr onto the return stack |
| push_addr | input | 21 | Return address to push |
| shadow_wr | input | 1 | Load the shadow copies |
| shadow_w_in | input | 8 | Shadow value for W |
| shadow_status_in | input | 8 | Shadow value for STATUS |
| shadow_bsr_in | input | 4 | Shadow value for the bank select |
| prio_en | input | 1 | Interrupt priority levels enabled |
| in_high_isr | input | 1 | Returning from a high-priority handler |
| phase | output | 2 | Current phase within the instruction cycle |
| busy | output | 1 | Flush cycle in progress |
| pop | output | 1 | Stack pop strobe |
| tos | output | 21 | Top-of-stack value (0 when empty) |
| depth | output | 5 | Number of stack entries |
| underflow | output | 1 | Sticky empty-pop flag |
| pc | output | 21 | Program counter |
| wreg | output | 8 | Accumulator W |
| status | output | 8 | STATUS register |
| bank_sel | output | 4 | Bank-select register |
| ie_high | output | 1 | High-priority global interrupt enable |
| ie_low | output | 1 | Low-priority global interrupt enable |

## Verification
The hardest case to reach from the ports is a word offered during the flush cycle. It must be driven after the execute edge but before `busy` falls, which means timing the stimulus to the phase counter rather than to the handshake. The bench waits four clocks after a literal return is taken and then offers a second literal return. It then checks that W holds the first literal and that the stack lost only one entry. An empty-stack pop is reached by draining the preloaded stack with returns until `depth` reads zero and then issuing one more return.

// File: rtl/ret_seq.sv
module ret_seq #(
  parameter int PC_W  = 21,
  parameter int DEPTH = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       instr,
  input  logic              instr_valid,
  input  logic              push_en,
  input  logic [PC_W-1:0]   push_addr,
  input  logic              shadow_wr,
  input  logic [7:0]        shadow_w_in,
  input  logic [7:0]        shadow_status_in,
  input  logic [3:0]        shadow_bsr_in,
  input  logic              prio_en,
  input  logic              in_high_isr,
  output logic [1:0]        phase,
  output logic              busy,
  output logic              pop,
  output logic [PC_W-1:0]   tos,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic              underflow,
  output logic [PC_W-1:0]   pc,
  output logic [7:0]        wreg,
  output logic [7:0]        status,
  output logic [3:0]        bank_sel,
  output logic              ie_high,
  output logic              ie_low
);
  localparam int SP_W = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_FLUSH} st_t;
  st_t st;

  logic [PC_W-1:0] stk [DEPTH];
  logic [SP_W-1:0] sp;
  logic            op_lit, op_s;
  logic [7:0]      op_k;
  logic [7:0]      sh_w, sh_status;
  logic [3:0]      sh_bsr;

  wire hit_rfie = instr[15:1] == 15'b000000000001000;
  wire hit_rlw  = instr[15:8] == 8'h0C;
  wire take     = instr_valid && st == S_IDLE && phase == 2'd0 && (hit_rfie || hit_rlw);
  wire empty    = sp == '0;
  wire full     = sp == SP_W'(DEPTH);
  wire [SP_W-1:0] top_idx = sp - SP_W'(1);
  wire push_ok  = push_en && !pop && !full;
  wire hi_sel   = !prio_en || in_high_isr;

  assign pop   = st == S_EXEC && phase == 2'd3;
  assign busy  = st == S_FLUSH;
  assign tos   = empty ? '0 : stk[top_idx];
  assign depth = sp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= 2'd0;
    else        phase <= phase + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_lit <= 1'b0;
      op_s <= 1'b0;
      op_k <= '0;
    end else begin
      if (take) begin
        st <= S_EXEC;
        op_lit <= hit_rlw;
        op_s <= instr[0];
        op_k <= instr[7:0];
      end else if (phase == 2'd3) begin
        if (st == S_EXEC)       st <= S_FLUSH;
        else if (st == S_FLUSH) st <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk)
    if (push_ok) stk[sp[SP_W-1:0]] <= push_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      underflow <= 1'b0;
      pc <= '0;
    end else if (pop) begin
      pc <= tos;
      if (empty) underflow <= 1'b1;
      else       sp <= top_idx;
    end else if (push_ok) begin
      sp <= sp + SP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_w <= '0;
      sh_status <= '0;
      sh_bsr <= '0;
    end else if (shadow_wr) begin
      sh_w <= shadow_w_in;
      sh_status <= shadow_status_in;
      sh_bsr <= shadow_bsr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wreg <= '0;
      status <= '0;
      bank_sel <= '0;
      ie_high <= 1'b0;
      ie_low <= 1'b0;
    end else if (pop) begin
      if (op_lit) begin
        wreg <= op_k;
      end else begin
        if (op_s) begin
          wreg <= sh_w;
          status <= sh_status;
          bank_sel <= sh_bsr;
        end
        if (hi_sel) ie_high <= 1'b1;
        else        ie_low <= 1'b1;
      end
    end
  end

  assert_flush_after_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> busy);
  assert_flush_blocks_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pop);
  assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty) |=> (depth == $past(depth) - SP_W'(1)) && (pc == $past(tos)));
  assert_literal_to_w_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && op_lit) |=> wreg == $past(op_k) && $stable(status) && $stable(ie_high));
  assert_enable_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_high || ie_low) |=> (ie_high || ie_low));
  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  assert_empty_pop_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> pc == '0 && underflow);
endmodule

// File: tb/ret_seq_tb.sv
module ret_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic instr_valid = 1'b0, push_en = 1'b0, shadow_wr = 1'b0;
  logic [20:0] push_addr = '0;
  logic [7:0] shadow_w_in = '0, shadow_status_in = '0;
  logic [3:0] shadow_bsr_in = '0;
  logic prio_en = 1'b0, in_high_isr = 1'b0;
  logic [1:0] phase;
  logic busy, pop, underflow, ie_high, ie_low;
  logic [20:0] tos, pc;
  logic [4:0] depth;
  logic [7:0] wreg, status;
  logic [3:0] bank_sel;

  ret_seq u_dut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [20:0] pc; logic [7:0] w; logic [7:0] st; logic [3:0] bsr;
    logic gh; logic gl; logic [4:0] sp; logic uf;
  } exp_t;

  exp_t exp_q[$];
  int mstk[$];
  exp_t m;
  logic [7:0] msh_w = 0, msh_st = 0;
  logic [3:0] msh_bsr = 0;
  int checks = 0, fails = 0, pops_seen = 0, pops_exp = 0, busy_rises = 0;
  logic busy_q = 1'b0;
  bit done = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t snap();
    exp_t e;
    e.pc = pc; e.w = wreg; e.st = status; e.bsr = bank_sel;
    e.gh = ie_high; e.gl = ie_low; e.sp = depth; e.uf = underflow;
    return e;
  endfunction

  task automatic cmp(string req, exp_t e);
    check({req, " pc"}, 64'(pc), 64'(e.pc));
    check({req, " w"}, 64'(wreg), 64'(e.w));
    check({req, " status"}, 64'(status), 64'(e.st));
    check({req, " bsr"}, 64'(bank_sel), 64'(e.bsr));
    check({req, " ie"}, 64'({ie_high, ie_low}), 64'({e.gh, e.gl}));
    check({req, " depth"}, 64'(depth), 64'(e.sp));
    check({req, " underflow"}, 64'(underflow), 64'(e.uf));
  endtask

  always @(negedge clk) begin
    if (pop) pops_seen++;
    if (busy && !busy_q) begin
      busy_rises++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 actual=unexpected flush expected=none");
      end else cmp("R2/R3 result", exp_q.pop_front());
    end
    busy_q <= busy;
  end

  task automatic push(int a);
    @(negedge clk);
    push_en = 1'b1; push_addr = 21'(a);
    @(negedge clk);
    push_en = 1'b0;
    if (mstk.size() < 31) mstk.push_back(a);
    m.sp = 5'(mstk.size());
  endtask

  task automatic load_shadow(logic [7:0] w, logic [7:0] s, logic [3:0] b);
    @(negedge clk);
    shadow_wr = 1'b1; shadow_w_in = w; shadow_status_in = s; shadow_bsr_in = b;
    @(negedge clk);
    shadow_wr = 1'b0;
    msh_w = w; msh_st = s; msh_bsr = b;
  endtask

  task automatic model(logic [15:0] word);
    bit rf = word[15:1] == 15'b000000000001000;
    bit rl = word[15:8] == 8'h0C;
    if (!(rf || rl)) return;
    pops_exp++;
    if (mstk.size() == 0) begin m.pc = 0; m.uf = 1'b1; end
    else m.pc = 21'(mstk.pop_back());
    m.sp = 5'(mstk.size());
    if (rl) m.w = word[7:0];
    else begin
      if (word[0]) begin m.w = msh_w; m.st = msh_st; m.bsr = msh_bsr; end
      if (!prio_en || in_high_isr) m.gh = 1'b1; else m.gl = 1'b1;
    end
    exp_q.push_back(m);
  endtask

  task automatic issue(logic [15:0] word, bit poke_in_flush = 0);
    @(negedge clk);
    while (!(phase == 2'd0 && !busy)) @(negedge clk);
    instr = word; instr_valid = 1'b1;
    model(word);
    @(negedge clk);
    instr_valid = 1'b0;
    if (poke_in_flush) begin
      repeat (3) @(negedge clk);
      instr = 16'h0C99; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      repeat (4) @(negedge clk);
    end else repeat (8) @(negedge clk);
  endtask

  initial begin
    m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy", 64'(busy), 64'(0));
    cmp("R10 reset", '0);

    for (int i = 1; i <= 5; i++) push(i * 16'h111);
    check("R11 depth", 64'(depth), 64'(5));
    check("R11 tos", 64'(tos), 64'(5 * 16'h111));

    load_shadow(8'h5A, 8'h1F, 4'h3);
    prio_en = 1'b1; in_high_isr = 1'b0;
    issue(16'h0010);                  // R5 s=0, R6 low enable
    issue(16'h0C07);                  // R4
    issue(16'h0CFF);                  // R4
    issue(16'h0C00);                  // R4
    in_high_isr = 1'b1;
    issue(16'h0011);                  // R5 s=1, R6 high enable
    check("R5 restored w", 64'(wreg), 64'(8'h5A));

    for (int i = 0; i < 4; i++) push(32'h1A000 + i);
    load_shadow(8'hC3, 8'h0A, 4'hE);
    prio_en = 1'b0; in_high_isr = 1'b0;
    issue(16'h0010);                  // R5 s=0 keeps earlier values
    check("R5 status kept", 64'(status), 64'(8'h1F));

    m = snap();
    issue(16'h0012);                  // R8 / R1 near misses
    issue(16'h0013);
    issue(16'h0D10);
    issue(16'h8010);
    issue(16'h0000);
    cmp("R8 no change", m);
    check("R8 no busy", 64'(busy_rises), 64'(pops_exp));

    issue(16'h0C42, 1);               // R9 word in flush ignored
    check("R9 w", 64'(wreg), 64'(8'h42));
    check("R9 depth", 64'(depth), 64'(m.sp));

    while (mstk.size() > 0) issue(16'h0C01);
    issue(16'h0C55);                  // R7 empty pop
    check("R7 pc", 64'(pc), 64'(0));
    check("R7 underflow", 64'(underflow), 64'(1));
    push(21'h1234);
    issue(16'h0C66);
    check("R7 sticky", 64'(underflow), 64'(1));

    for (int i = 0; i < 31; i++) push(21'h100 + i);
    push(21'h1FFFF);                  // R11 full push ignored
    check("R11 full depth", 64'(depth), 64'(31));
    check("R11 full tos", 64'(tos), 64'(21'h100 + 30));

    check("R3 pop count", 64'(pops_seen), 64'(pops_exp));
    check("R2 queue drained", 64'(exp_q.size()), 64'(0));
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule